// File: doc/BRIEF.md
# Serial Port Handshake Pin Controller

This block manages the two handshake pins of an asynchronous serial port. The first pin is input-only. It either gates the transmitter as a clear-to-send input or serves as a plain one-bit input. The second pin can be set up as a request-to-send output, as a general-purpose output, or as a general-purpose input for sensing carrier-detect or data-set-ready. A two-bit role field chooses between these three uses.

Both pins are active low. Each pin input passes through a two-flop synchronizer. The host sees the inverted, synchronized pin levels as two status bits. When the second pin drives, its level comes from a control bit that the host writes.

The block also produces the transmit-enable gate used by the transmitter. This gate is only reloaded while the transmitter reports that it is idle between characters. A character that is already shifting out therefore always finishes, and the line then returns to mark.

Top module: `hs_pins`

## Requirements
- R1: After reset, `stat_cp1` and `stat_cp2` read 0, `tx_enable` reads 0 and `cp2_pin_o` reads 1 (the pin is released high).
- R2: `stat_cp1` equals the inverted level of `cp1_pin_i`, two clock edges after the pin changes. This holds in both pin-1 roles.
- R3: With `cfg_cp1_gp` = 0 (clear-to-send role) and `tx_busy` low, `tx_enable` equals the inverted level of `cp1_pin_i`, three clock edges after the pin changes.
- R4: While `tx_busy` is high at a clock edge, `tx_enable` keeps its value across that edge. The first edge with `tx_busy` low reloads it.
- R5: With `cfg_cp1_gp` = 1 (general-purpose role), `tx_enable` becomes 1 at the first edge with `tx_busy` low, whatever the level of `cp1_pin_i`.
- R6: When `cfg_cp2_role` is 00 (request-to-send) or 01 (general-purpose output), `cp2_pin_oe` is 1. A pulse on `ctl_wr` stores `ctl_cp2_level` at the next edge, and `cp2_pin_o` then drives its inverse (stored 1 drives the pin low).
- R7: When `cfg_cp2_role[1]` is 1 (general-purpose input), `cp2_pin_oe` is 0. `stat_cp2` then equals the inverted level of `cp2_pin_i`, two clock edges after the pin changes.
- R8: When `cfg_cp2_role[1]` is 0, `stat_cp2` reads 0, whatever the level of `cp2_pin_i`.
- R9: A control write made while pin 2 is an input is still stored. Switching the role to an output drives the stored level at once, with no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cp1_gp | input | 1 | Pin-1 role: 0 = clear-to-send gate, 1 = general-purpose input |
| cfg_cp2_role | input | 2 | Pin-2 role: 00 = request-to-send output, 01 = general-purpose output, 1X = general-purpose input |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_cp2_level | input | 1 | Written pin-2 assert level (1 = drive low) |
| cp1_pin_i | input | 1 | Pin 1 level from the pad |
| cp2_pin_i | input | 1 | Pin 2 level from the pad |
| cp2_pin_o | output | 1 | Pin 2 drive value |
| cp2_pin_oe | output | 1 | Pin 2 output enable |
| stat_cp1 | output | 1 | Status: inverted synchronized pin 1 |
| stat_cp2 | output | 1 | Status: inverted synchronized pin 2 (input role only) |
| tx_busy | input | 1 | Transmitter is shifting a character |
| tx_enable | output | 1 | Transmit enable gate for new characters |

## Verification
Each result has its own latency, counted from a pin change that lands between edges:
- The status bits follow the pin two edges later.
- The clear-to-send gate follows one edge after that, at the third edge.
- A control write shows on the pin drive after one edge.
- A change of role moves the output enable and the drive value with no edge at all.

Every scenario drives its inputs and samples the outputs a short delay after a rising edge. It checks the old value one edge before the due edge, then the new value on the due edge. A result that is early fails, and so does one that is late.

// File: rtl/hs_pins.sv
module hs_pins #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_cp1_gp,
  input  logic [1:0] cfg_cp2_role,
  input  logic       ctl_wr,
  input  logic       ctl_cp2_level,
  input  logic       cp1_pin_i,
  input  logic       cp2_pin_i,
  output logic       cp2_pin_o,
  output logic       cp2_pin_oe,
  output logic       stat_cp1,
  output logic       stat_cp2,
  input  logic       tx_busy,
  output logic       tx_enable
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cp1_q, cp2_q;
  logic          cp2_level_q;
  logic          tx_en_q;
  logic          cp2_is_input;

  // pads idle high, so synchronizers reset to the deasserted level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp1_q <= '1;
      cp2_q <= '1;
    end else begin
      cp1_q <= {cp1_q[LAST-1:0], cp1_pin_i};
      cp2_q <= {cp2_q[LAST-1:0], cp2_pin_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cp2_level_q <= 1'b0;
    else if (ctl_wr) cp2_level_q <= ctl_cp2_level;
  end

  // gate reloads only between characters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_en_q <= 1'b0;
    else if (!tx_busy) tx_en_q <= cfg_cp1_gp | ~cp1_q[LAST];
  end

  assign cp2_is_input = cfg_cp2_role[1];
  assign cp2_pin_oe   = ~cp2_is_input;
  assign cp2_pin_o    = ~cp2_level_q;
  assign stat_cp1     = ~cp1_q[LAST];
  assign stat_cp2     = cp2_is_input & ~cp2_q[LAST];
  assign tx_enable    = tx_en_q;

endmodule

module hs_pins_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_cp1_gp,
  input logic [1:0] cfg_cp2_role,
  input logic       ctl_wr,
  input logic       ctl_cp2_level,
  input logic       cp2_pin_o,
  input logic       cp2_pin_oe,
  input logic       stat_cp2,
  input logic       tx_busy,
  input logic       tx_enable
);

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy) |-> $stable(tx_enable)); // R4

  AST_GP_GATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cp1_gp && !tx_busy) |=> tx_enable); // R5

  AST_CTL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (cp2_pin_o == !$past(ctl_cp2_level))); // R6

  AST_OE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    cp2_pin_oe != cfg_cp2_role[1]); // R7

  AST_STAT2_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cp2_role[1] |-> !stat_cp2); // R8

endmodule

bind hs_pins hs_pins_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cp1_gp(cfg_cp1_gp), .cfg_cp2_role(cfg_cp2_role),
  .ctl_wr(ctl_wr), .ctl_cp2_level(ctl_cp2_level), .cp2_pin_o(cp2_pin_o),
  .cp2_pin_oe(cp2_pin_oe), .stat_cp2(stat_cp2), .tx_busy(tx_busy),
  .tx_enable(tx_enable)
);

// File: tb/tb_hs_pins.sv
module tb_hs_pins;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_cp1_gp = 1'b0;
  logic [1:0] cfg_cp2_role = 2'b10;
  logic       ctl_wr = 1'b0;
  logic       ctl_cp2_level = 1'b0;
  logic       cp1_pin_i = 1'b1;
  logic       cp2_pin_i = 1'b1;
  logic       tx_busy = 1'b0;
  logic       cp2_pin_o, cp2_pin_oe, stat_cp1, stat_cp2, tx_enable;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_pins dut (
    .clk(clk), .rst_n(rst_n), .cfg_cp1_gp(cfg_cp1_gp), .cfg_cp2_role(cfg_cp2_role),
    .ctl_wr(ctl_wr), .ctl_cp2_level(ctl_cp2_level), .cp1_pin_i(cp1_pin_i),
    .cp2_pin_i(cp2_pin_i), .cp2_pin_o(cp2_pin_o), .cp2_pin_oe(cp2_pin_oe),
    .stat_cp1(stat_cp1), .stat_cp2(stat_cp2), .tx_busy(tx_busy), .tx_enable(tx_enable)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // advance n rising edges, then settle to a point away from the edge
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    chk("R1", "stat_cp1", stat_cp1, 1'b0);
    chk("R1", "stat_cp2", stat_cp2, 1'b0);
    chk("R1", "tx_enable", tx_enable, 1'b0);
    chk("R1", "cp2_pin_o", cp2_pin_o, 1'b1);
  endtask

  task automatic t_cp1_status;
    cfg_cp1_gp = 1'b0;
    cp1_pin_i = 1'b0;
    step(1); chk("R2", "stat_cp1 early", stat_cp1, 1'b0);
    step(1); chk("R2", "stat_cp1 low pin", stat_cp1, 1'b1);
    cfg_cp1_gp = 1'b1;
    cp1_pin_i = 1'b1;
    step(1); chk("R2", "stat_cp1 gp early", stat_cp1, 1'b1);
    step(1); chk("R2", "stat_cp1 gp high pin", stat_cp1, 1'b0);
  endtask

  task automatic t_cts;
    cfg_cp1_gp = 1'b0;
    tx_busy = 1'b0;
    step(2); chk("R3", "tx_enable closed", tx_enable, 1'b0);
    cp1_pin_i = 1'b0;
    step(2); chk("R3", "tx_enable before due", tx_enable, 1'b0);
    step(1); chk("R3", "tx_enable open", tx_enable, 1'b1);
  endtask

  task automatic t_busy_hold;
    tx_busy = 1'b1;
    cp1_pin_i = 1'b1;
    step(6); chk("R4", "tx_enable held while busy", tx_enable, 1'b1);
    tx_busy = 1'b0;
    step(1); chk("R4", "tx_enable reload when idle", tx_enable, 1'b0);
  endtask

  task automatic t_gp_gate;
    cp1_pin_i = 1'b1;
    cfg_cp1_gp = 1'b1;
    step(1); chk("R5", "tx_enable gp pin high", tx_enable, 1'b1);
    cp1_pin_i = 1'b0;
    step(3); chk("R5", "tx_enable gp pin low", tx_enable, 1'b1);
  endtask

  task automatic t_cp2_out;
    cfg_cp2_role = 2'b00;
    cp2_pin_i = 1'b0;
    ctl_wr = 1'b1; ctl_cp2_level = 1'b1;
    #1; chk("R6", "cp2_pin_oe rts", cp2_pin_oe, 1'b1);
    chk("R6", "cp2_pin_o before edge", cp2_pin_o, 1'b1);
    step(1); ctl_wr = 1'b0;
    chk("R6", "cp2_pin_o rts asserted", cp2_pin_o, 1'b0);
    step(2); chk("R8", "stat_cp2 masked rts", stat_cp2, 1'b0);
    cfg_cp2_role = 2'b01;
    ctl_wr = 1'b1; ctl_cp2_level = 1'b0;
    step(1); ctl_wr = 1'b0;
    chk("R6", "cp2_pin_oe gp out", cp2_pin_oe, 1'b1);
    chk("R6", "cp2_pin_o gp released", cp2_pin_o, 1'b1);
    chk("R8", "stat_cp2 masked gp out", stat_cp2, 1'b0);
  endtask

  task automatic t_cp2_in;
    cfg_cp2_role = 2'b10;
    cp2_pin_i = 1'b1;
    step(3);
    chk("R7", "cp2_pin_oe input", cp2_pin_oe, 1'b0);
    chk("R7", "stat_cp2 high pin", stat_cp2, 1'b0);
    cp2_pin_i = 1'b0;
    step(1); chk("R7", "stat_cp2 early", stat_cp2, 1'b0);
    step(1); chk("R7", "stat_cp2 low pin", stat_cp2, 1'b1);
    cfg_cp2_role = 2'b11;
    #1; chk("R7", "cp2_pin_oe role 11", cp2_pin_oe, 1'b0);
    chk("R7", "stat_cp2 role 11", stat_cp2, 1'b1);
  endtask

  task automatic t_write_while_input;
    cfg_cp2_role = 2'b11;
    ctl_wr = 1'b1; ctl_cp2_level = 1'b1;
    step(1); ctl_wr = 1'b0;
    step(2);
    cfg_cp2_role = 2'b01;
    #1;
    chk("R9", "cp2_pin_oe after switch", cp2_pin_oe, 1'b1);
    chk("R9", "cp2_pin_o stored level", cp2_pin_o, 1'b0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cp1_status();
    t_cts();
    t_busy_hold();
    t_gp_gate();
    t_cp2_out();
    t_cp2_in();
    t_write_while_input();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule